// File: doc/BRIEF.md
# Synchronous Burst Memory with Selectable Output Latency

This block is a clocked single-port on-chip memory that works like a cache-style burst SRAM. Address, control and write data are taken on the rising clock edge. A strobe loads a base address and performs the first access. Each later advance request steps an internal two-bit beat counter, which produces the addresses of the next three words in a four-word burst. The beat order is linear or interleaved, and it is chosen when the burst starts.

A static mode input selects the read latency. In flow-through mode a read word appears in the cycle after the edge that sampled its address. In pipelined mode an extra output register adds one more cycle. In pipelined mode the block also holds off a write for one cycle after a read, and it signals this through a ready output. The requester keeps its write request asserted until the write is accepted. Chip enable suspends all activity. Output enable masks the read data and the valid flag.

Top module: `sbs_sram_top`

## Requirements
- R1: On a rising edge with `ce_i`=1 and `start_i`=1, the block loads `addr_i` as the burst base and performs beat 0 at that address. When `we_i`=1 the beat is a write of `wdata_i`, and when `we_i`=0 it is a read. A start that is accepted resets the beat index to 0.
- R2: When `order_i`=0 at the start edge (linear order), beat k (k=0..3) uses the base address with its two low bits replaced by (base[1:0]+k) mod 4. The upper address bits stay those of the base.
- R3: When `order_i`=1 at the start edge (interleaved order), beat k uses the base address with its two low bits replaced by base[1:0] XOR k. The upper address bits stay those of the base.
- R4: Each edge with `ce_i`=1, `start_i`=0, `adv_i`=1 and a burst in progress performs the next beat. The burst is over after beat 3. An advance with no burst in progress performs no access.
- R5: With `pipe_i`=0 (flow-through), a read whose address is sampled at edge N shows its word on `rdata_o`, with `rvalid_o`=1, in the cycle after edge N. A four-beat read burst therefore returns its data over four clocks.
- R6: With `pipe_i`=1 (pipelined), a read sampled at edge N shows its word in the cycle after edge N+1. A four-beat read burst therefore spans five clocks.
- R7: With `pipe_i`=1, `ready_o` is 0 in the cycle after any edge that performed a read. A write (start or write-burst advance) presented in that cycle is not performed. The requester holds it, and it is accepted one cycle later. Reads do not depend on `ready_o`.
- R8: While `ce_i`=0, no access takes place and the burst position is kept. A later advance continues with the beat that was due.
- R9: While `oe_i`=0, `rvalid_o` is 0 and `rdata_o` is 0. Reads still progress internally, so words whose slot falls in that cycle are lost.
- R10: A start during a burst abandons the rest of that burst and begins a new burst at the new address.
- R11: A write burst steps through the same address sequence as a read burst. It stores the `wdata_i` present at each accepted beat.
- R12: With `pipe_i`=0, `ready_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Chip enable; 0 suspends all accesses |
| oe_i | input | 1 | Output enable; 0 masks read data and valid |
| start_i | input | 1 | Address strobe: load base, perform beat 0 |
| adv_i | input | 1 | Burst advance: perform next beat |
| we_i | input | 1 | 1 = write burst, 0 = read burst (sampled at start) |
| order_i | input | 1 | 0 = linear, 1 = interleaved (sampled at start) |
| pipe_i | input | 1 | Static mode: 0 = flow-through, 1 = pipelined |
| addr_i | input | AW | Burst base address |
| wdata_i | input | DW | Write data for the current beat |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | Read data valid |
| ready_o | output | 1 | 0 = a write in this cycle is not accepted |

## Verification
For a read, the address is sampled at edge N. In flow-through mode the data is due in the cycle after edge N, and in pipelined mode in the cycle after edge N+1. `ready_o` depends only on whether edge N-1 performed a read, so it is due in the same cycle. The bench keeps a cycle-level reference that moves forward once per edge. It compares the outputs at the falling edge before it drives the next inputs, and it compares `ready_o` shortly after those inputs settle. Each result is therefore checked in exactly the cycle its register chain delivers it. Directed phases cover the R-tagged cases. A long random phase in both modes, using a fixed seed, mixes starts, advances, stalls, chip-enable gaps and output masking.

// File: rtl/sbs_pkg.sv
// Package: shared constants, burst order type and the beat address helper.
// Assumes bursts are always four beats, so the beat index is two bits wide.
package sbs_pkg;

    localparam int BEATS = 4;
    localparam int BEAT_W = $clog2(BEATS);

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_ord_e;

    // Low address bits of beat k for a given base and order.
    function automatic logic [BEAT_W-1:0] beat_lsb(
        input logic [BEAT_W-1:0] base_lsb,
        input logic [BEAT_W-1:0] k,
        input burst_ord_e        ord
    );
        logic [BEAT_W-1:0] r;
        if (ord == ORD_INTERLEAVE) r = base_lsb ^ k;
        else                       r = base_lsb + k;
        return r;
    endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
// Burst controller: accepts starts and advances, keeps the beat counter
// and burst attributes, and issues one array access per accepted cycle.
// Assumes rd_last_i is high for one cycle after the array served a read.
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_i,
    input  logic          start_i,
    input  logic          adv_i,
    input  logic          we_i,
    input  logic          order_i,
    input  logic          pipe_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_last_i,
    output logic          acc_vld_o,
    output logic          acc_we_o,
    output logic [AW-1:0] acc_addr_o,
    output logic [DW-1:0] acc_wdata_o,
    output logic          ready_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    logic              active_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [AW-1:0]     base_q;
    burst_ord_e        ord_q;
    logic              wr_q;

    logic              start_ok;
    logic              adv_ok;
    logic [BEAT_W-1:0] nxt_cnt;

    // Turnaround gate: writes wait one cycle after a pipelined read.
    always_comb begin
        ready_o = !(pipe_i && rd_last_i);
    end

    // Decide which request, if any, is served this cycle.
    always_comb begin
        nxt_cnt  = cnt_q + 1'b1;
        start_ok = ce_i && start_i && (!we_i || ready_o);
        adv_ok   = ce_i && !start_i && adv_i && active_q && (!wr_q || ready_o);
    end

    // Build the array access for the served request.
    always_comb begin
        acc_vld_o   = start_ok || adv_ok;
        acc_wdata_o = wdata_i;
        if (start_ok) begin
            acc_we_o   = we_i;
            acc_addr_o = addr_i;
        end else begin
            acc_we_o   = wr_q;
            acc_addr_o = {base_q[AW-1:BEAT_W], beat_lsb(base_q[BEAT_W-1:0], nxt_cnt, ord_q)};
        end
    end

    // Burst state: load on start, step on advance, close after last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            base_q   <= '0;
            ord_q    <= ORD_LINEAR;
            wr_q     <= 1'b0;
        end else if (start_ok) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            base_q   <= addr_i;
            ord_q    <= burst_ord_e'(order_i);
            wr_q     <= we_i;
        end else if (adv_ok) begin
            cnt_q <= nxt_cnt;
            if (nxt_cnt == LAST_BEAT) active_q <= 1'b0;
        end
    end

    // R8: a disabled cycle leaves the burst position untouched.
    p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> ($stable(cnt_q) && $stable(active_q)));

    // R2: consecutive linear beats differ by one in the low bits.
    p_lin_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ok && ord_q == ORD_LINEAR && $past(acc_vld_o))
        |-> (acc_addr_o[BEAT_W-1:0] == $past(acc_addr_o[BEAT_W-1:0]) + 1'b1));

    // R4: beats of one burst share the upper address bits.
    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ok && $past(acc_vld_o))
        |-> (acc_addr_o[AW-1:BEAT_W] == $past(acc_addr_o[AW-1:BEAT_W])));

endmodule

// File: rtl/sbs_array.sv
// Storage array with a registered read port: one access per cycle,
// read data appears after the edge that sampled the address.
// Assumes write and read never occur in the same cycle (single port).
module sbs_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_i,
    input  logic          acc_vld_i,
    input  logic          acc_we_i,
    input  logic [AW-1:0] acc_addr_i,
    input  logic [DW-1:0] acc_wdata_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_vld_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Cell writes; contents are not reset.
    always_ff @(posedge clk) begin
        if (acc_vld_i && acc_we_i) mem[acc_addr_i] <= acc_wdata_i;
    end

    // Registered read port and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            rd_vld_o  <= 1'b0;
        end else begin
            rd_vld_o <= acc_vld_i && !acc_we_i;
            if (acc_vld_i && !acc_we_i) rd_data_o <= mem[acc_addr_i];
        end
    end

    // R7: in pipelined mode no write lands right after a read.
    p_no_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && acc_we_i && pipe_i) |-> !rd_vld_o);

endmodule

// File: rtl/sbs_out_stage.sv
// Output stage: optional extra register for pipelined timing, then the
// output-enable mask. Assumes pipe_i changes only while no read is in flight.
module sbs_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_i,
    input  logic          oe_i,
    input  logic [DW-1:0] d_i,
    input  logic          v_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);

    logic [DW-1:0] d_q;
    logic          v_q;

    // Pipeline register between array and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
        end else begin
            d_q <= d_i;
            v_q <= v_i;
        end
    end

    // Timing select and output-enable mask.
    always_comb begin
        data_o  = '0;
        valid_o = 1'b0;
        if (oe_i) begin
            data_o  = pipe_i ? d_q : d_i;
            valid_o = pipe_i ? v_q : v_i;
        end
    end

endmodule

// File: rtl/sbs_sram_top.sv
// Top: synchronous burst memory with linear/interleaved four-beat bursts,
// flow-through or pipelined reads and a read-to-write gap in pipelined mode.
// Assumes pipe_i is static while accesses are in flight.
module sbs_sram_top #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_i,
    input  logic          oe_i,
    input  logic          start_i,
    input  logic          adv_i,
    input  logic          we_i,
    input  logic          order_i,
    input  logic          pipe_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o,
    output logic          ready_o
);

    logic          acc_vld;
    logic          acc_we;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_wdata;
    logic [DW-1:0] rd_data;
    logic          rd_vld;

    sbs_burst_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_i       (ce_i),
        .start_i    (start_i),
        .adv_i      (adv_i),
        .we_i       (we_i),
        .order_i    (order_i),
        .pipe_i     (pipe_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rd_last_i  (rd_vld),
        .acc_vld_o  (acc_vld),
        .acc_we_o   (acc_we),
        .acc_addr_o (acc_addr),
        .acc_wdata_o(acc_wdata),
        .ready_o    (ready_o)
    );

    sbs_array #(.AW(AW), .DW(DW)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_i     (pipe_i),
        .acc_vld_i  (acc_vld),
        .acc_we_i   (acc_we),
        .acc_addr_i (acc_addr),
        .acc_wdata_i(acc_wdata),
        .rd_data_o  (rd_data),
        .rd_vld_o   (rd_vld)
    );

    sbs_out_stage #(.DW(DW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pipe_i (pipe_i),
        .oe_i   (oe_i),
        .d_i    (rd_data),
        .v_i    (rd_vld),
        .data_o (rdata_o),
        .valid_o(rvalid_o)
    );

    // R5: flow-through read shows valid one cycle after its edge.
    p_ft_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_we && !pipe_i) |=> (rvalid_o || !oe_i));

    // R6: pipelined read shows valid two cycles after its edge.
    p_pipe_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_we && pipe_i) |=> ##1 (rvalid_o || !oe_i));

endmodule

// File: tb/sim_sbs_sram_top.sv
`timescale 1ns/1ps
// Bench: cycle-level reference model, directed phases plus seeded random.
module sim_sbs_sram_top;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 0, oe = 0, st = 0, adv = 0, we = 0, ord = 0, pipe = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] rdata;
    logic          rvalid, ready;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "reset";

    // Reference model state.
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_act, m_wr, m_ord;
    int            m_cnt;
    logic [AW-1:0] m_base;
    bit            m_r1v, m_r2v;
    logic [DW-1:0] m_r1d, m_r2d;

    always #4 clk = ~clk;

    sbs_sram_top #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_i(ce), .oe_i(oe), .start_i(st),
        .adv_i(adv), .we_i(we), .order_i(ord), .pipe_i(pipe),
        .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .rvalid_o(rvalid),
        .ready_o(ready)
    );

    function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] b, int k, bit o);
        int lo;
        lo = o ? (int'(b[1:0]) ^ k) : ((int'(b[1:0]) + k) % 4);
        return {b[AW-1:2], 2'(lo)};
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare outputs due for this cycle under the current oe.
    task automatic cmp_out();
        bit ev;
        logic [DW-1:0] ed;
        ev = pipe ? m_r2v : m_r1v;
        ed = pipe ? m_r2d : m_r1d;
        chk("rvalid", DW'(rvalid), DW'(ev && oe));
        if (!oe) chk("rdata masked", rdata, '0);
        else if (ev) chk("rdata", rdata, ed);
    endtask

    // One clock: check, drive, check ready, advance model, pass the edge.
    task automatic cyc(input bit c, input bit s, input bit a, input bit w,
                       input bit o, input bit e, input logic [AW-1:0] ad,
                       input logic [DW-1:0] d);
        bit rdy, sok, aok, aw;
        logic [AW-1:0] aa;
        cmp_out();
        ce = c; st = s; adv = a; we = w; ord = o; oe = e; addr = ad; wd = d;
        #1;
        rdy = !(pipe && m_r1v);
        chk("ready", DW'(ready), DW'(rdy));
        sok = c && s && (!w || rdy);
        aok = c && !s && a && m_act && (!m_wr || rdy);
        aw = 0; aa = '0;
        if (sok) begin aa = ad; aw = w; end
        else if (aok) begin aa = beat_addr(m_base, m_cnt + 1, m_ord); aw = m_wr; end
        m_r2v = m_r1v; m_r2d = m_r1d;
        m_r1v = (sok || aok) && !aw;
        if ((sok || aok) && !aw) m_r1d = m_mem[aa];
        if ((sok || aok) && aw) m_mem[aa] = d;
        if (sok) begin m_act = 1; m_cnt = 0; m_base = ad; m_ord = o; m_wr = w; end
        else if (aok) begin m_cnt++; if (m_cnt == 3) m_act = 0; end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 1, '0, '0);
    endtask

    task automatic rd_burst(input logic [AW-1:0] b, input bit o);
        cyc(1, 1, 0, 0, o, 1, b, '0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, o, 1, '0, '0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        tag = "reset";
        chk("rvalid", DW'(rvalid), '0);
        chk("ready", DW'(ready), 16'd1);
        rst_n = 1'b1;
        m_act = 0; m_wr = 0; m_ord = 0; m_cnt = 0; m_base = '0;
        m_r1v = 0; m_r2v = 0; m_r1d = '0; m_r2d = '0;
        void'($urandom(32'd1234));

        tag = "R11 R1 R12 write bursts";
        for (int b = 0; b < DEPTH; b += 4) begin
            cyc(1, 1, 0, 1, 0, 1, AW'(b), DW'($urandom));
            for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, 1, '0, DW'($urandom));
        end
        tag = "R5 R2 flow linear"; rd_burst(8'h0A, 0); idle(3);
        tag = "R3 interleave";     rd_burst(8'h16, 1); idle(3);
        tag = "R4 extra advance";
        rd_burst(8'h31, 0);
        cyc(1, 0, 1, 0, 0, 1, '0, '0); cyc(1, 0, 1, 0, 0, 1, '0, '0); idle(2);
        tag = "R10 abort";
        cyc(1, 1, 0, 0, 0, 1, 8'h20, '0); cyc(1, 0, 1, 0, 0, 1, '0, '0);
        rd_burst(8'h47, 1); idle(2);
        tag = "R8 chip disable";
        cyc(1, 1, 0, 0, 0, 1, 8'h52, '0);
        cyc(0, 1, 1, 1, 0, 1, 8'h99, 16'hDEAD);
        cyc(0, 0, 1, 0, 0, 1, '0, '0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 0, 1, '0, '0);
        idle(2);
        tag = "R9 output masked";
        cyc(1, 1, 0, 0, 1, 0, 8'h63, '0);
        cyc(1, 0, 1, 0, 1, 0, '0, '0);
        cyc(1, 0, 1, 0, 1, 1, '0, '0);
        cyc(1, 0, 1, 0, 1, 0, '0, '0);
        idle(2);

        pipe = 1; idle(2);
        tag = "R6 pipelined"; rd_burst(8'h74, 0); idle(3);
        tag = "R7 turnaround";
        cyc(1, 1, 0, 0, 0, 1, 8'h80, '0);
        cyc(1, 1, 0, 1, 0, 1, 8'h85, 16'hBEEF);
        cyc(1, 1, 0, 1, 0, 1, 8'h85, 16'hBEEF);
        idle(1);
        cyc(1, 1, 0, 0, 0, 1, 8'h85, '0); idle(3);
        tag = "R7 write burst after read";
        cyc(1, 1, 0, 0, 0, 1, 8'h90, '0);
        cyc(1, 1, 0, 1, 1, 1, 8'h93, 16'h1111);
        cyc(1, 1, 0, 1, 1, 1, 8'h93, 16'h1111);
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 1, 1, '0, DW'(16'h2222 + i));
        rd_burst(8'h93, 1); idle(3);

        for (int ph = 0; ph < 2; ph++) begin
            pipe = ph[0];
            idle(3);
            tag = ph ? "R1 R6 R7 random" : "R1 R5 R12 random";
            for (int n = 0; n < 3000; n++) begin
                cyc(($urandom % 10) != 0, ($urandom % 5) == 0, ($urandom % 10) < 7,
                    ($urandom % 5) < 2, $urandom % 2, ($urandom % 8) != 0,
                    AW'($urandom % 24), DW'($urandom));
            end
            cyc(1, 0, 0, 0, 0, 1, '0, '0);
            idle(3);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule